// File: doc/BRIEF.md
# Branch and Stack Transfer Sequencer

This block steps an 8-bit processor through its control-transfer instructions over a 16-bit address space: absolute and relative jumps, subroutine calls, returns, return-from-interrupt, restarts to a fixed vector, and a jump to the register pair HL. The surrounding core decodes the opcode and presents an operation code, a condition code, the carry and zero flags, and the current PC, SP and HL on a one-cycle `start` pulse. The block then runs a fixed cycle sequence. It fetches operand bytes at the PC, pushes or pops the return address through SP, and ends with a one-cycle `done`. At that point `pc_out` and `sp_out` hold the architectural results.

The memory side is a plain single-cycle byte port. In a cycle where `mem_rd` is high, the memory must return the byte at `mem_addr` on `mem_rdata` within that same cycle. A cycle with `mem_wr` high stores `mem_wdata` at `mem_addr`. There is no back-pressure: every access completes in exactly one clock, and at most one access happens per cycle.

The latency of each operation is part of its contract. Taken branches spend an extra internal cycle, and untaken ones end as soon as their operand bytes have been read. All PC and SP arithmetic wraps modulo 65536.

Top module: `branch_stack_seq`

## Requirements
- R1: After reset, and whenever reset is applied during an operation, `pc_out` and `sp_out` are 0 and `done`, `ie_set`, `mem_rd` and `mem_wr` are low.
- R2: Condition codes are 0 always, 1 carry set, 2 zero set, 3 carry clear and 4 zero clear. The flags are captured in the cycle `start` is accepted, and flag changes after that have no effect on the operation.
- R3: Absolute jump (op 0) reads the low target byte at PC, then the high byte at PC+1. If taken, PC becomes {high, low} and one settle cycle follows (done 4 cycles after start). If not taken, PC becomes PC+2 (done after 3 cycles).
- R4: Relative jump (op 1) reads one byte at PC and treats it as a signed offset. If taken, PC becomes PC+1+offset with one settle cycle (done after 3 cycles). If not taken, PC becomes PC+1 (done after 2 cycles).
- R5: Call (op 2) reads two target bytes. If not taken, PC becomes PC+2 with SP unchanged (done after 3 cycles). If taken, it spends one internal cycle, then writes (PC+2)[15:8] at SP-1 and (PC+2)[7:0] at SP-2. SP ends at SP-2 and PC at the target (done after 6 cycles).
- R6: Return (op 3) with the always condition goes straight to the stack (done after 4 cycles). Any other condition first spends one internal cycle; if not taken it ends there (done after 2 cycles), and if taken it is done after 5 cycles. A taken return reads the low byte at SP and the high byte at SP+1, adds 2 to SP, then spends one settle cycle.
- R7: Return-from-interrupt (op 4) behaves as an unconditional return and raises `ie_set` for exactly the one cycle in which `done` is high. No other operation raises `ie_set`.
- R8: Restart (op 5) spends one internal cycle, then writes PC[15:8] at SP-1 and PC[7:0] at SP-2. PC becomes `vec_sel`×8 and SP becomes SP-2 (done after 4 cycles).
- R9: Jump-to-HL (op 6) loads PC from `hl_in` with no memory access; `done` is high in the cycle after `start`.
- R10: `done` is high for exactly one cycle per operation. A `start` while an operation is in progress is ignored. While idle without `start`, PC and SP hold their values.
- R11: PC and SP arithmetic wraps modulo 65536, for operand fetches, relative offsets, pushes and pops.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle, and each stack write decreases SP by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| op_sel | input | 3 | Operation code (0 jump, 1 relative, 2 call, 3 return, 4 return-from-interrupt, 5 restart, 6 jump-to-HL) |
| cond_sel | input | 3 | Condition code (see R2) |
| vec_sel | input | 3 | Restart vector index |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| pc_in | input | 16 | PC after the opcode byte, sampled at start |
| sp_in | input | 16 | SP, sampled at start |
| hl_in | input | 16 | HL pair, sampled at start |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc_out | output | 16 | Program counter |
| sp_out | output | 16 | Stack pointer |
| ie_set | output | 1 | Interrupt-enable set pulse |
| done | output | 1 | Operation complete pulse |

## Verification
A sequencer stuck in or skipping a step shows first as a wrong `done` latency, and the bench measures that to the exact cycle for every operation and condition outcome. A wrong pointer or operand register shows at the port in the same cycle as a misplaced `mem_addr` on a push or pop. At the latest it shows as a wrong `pc_out` or `sp_out` in the `done` cycle. Condition mishandling appears as the taken/untaken latency difference of one or more cycles. Stack traffic is compared write by write against independently computed addresses and bytes.

// File: rtl/bsq_pkg.sv
`timescale 1ns/1ps
package bsq_pkg;

  typedef enum logic [2:0] {
    OP_JABS = 3'd0,
    OP_JREL = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4,
    OP_RST  = 3'd5,
    OP_JHL  = 3'd6,
    OP_NONE = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0,
    CC_CSET   = 3'd1,
    CC_ZSET   = 3'd2,
    CC_CCLR   = 3'd3,
    CC_ZCLR   = 3'd4
  } cc_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPND_LO,
    ST_OPND_HI,
    ST_INTERNAL,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_LO,
    ST_POP_HI,
    ST_SETTLE
  } step_e;

endpackage

// File: rtl/bsq_cond.sv
`timescale 1ns/1ps
module bsq_cond
  import bsq_pkg::*;
(
  input  logic [2:0] cc,
  input  logic       fc,
  input  logic       fz,
  output logic       taken
);

  always_comb begin
    case (cc)
      3'(CC_CSET): taken = fc;
      3'(CC_ZSET): taken = fz;
      3'(CC_CCLR): taken = !fc;
      3'(CC_ZCLR): taken = !fz;
      default:     taken = 1'b1;
    endcase
  end

endmodule

// File: rtl/bsq_ctrl.sv
`timescale 1ns/1ps
module bsq_ctrl
  import bsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] op_sel,
  input  logic [2:0] cond_sel,
  input  logic       flag_c,
  input  logic       flag_z,
  input  logic       taken,
  output step_e      state,
  output logic [2:0] cc_q,
  output logic       fc_q,
  output logic       fz_q,
  output logic       start_acc,
  output logic       idle,
  output logic       done,
  output logic       ie_set
);

  step_e nxt;
  op_e   op_q;
  op_e   op_in;
  logic  fin;

  assign op_in     = op_e'(op_sel);
  assign idle      = (state == ST_IDLE);
  assign start_acc = idle && start;

  always_comb begin
    nxt = state;
    fin = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          case (op_in)
            OP_JABS, OP_JREL, OP_CALL: nxt = ST_OPND_LO;
            OP_RET:  nxt = (cond_sel == 3'(CC_ALWAYS)) ? ST_POP_LO : ST_INTERNAL;
            OP_RETI: nxt = ST_POP_LO;
            OP_RST:  nxt = ST_INTERNAL;
            default: fin = 1'b1;
          endcase
        end
      end
      ST_OPND_LO: begin
        if (op_q == OP_JREL) begin
          if (taken) nxt = ST_SETTLE;
          else       fin = 1'b1;
        end else begin
          nxt = ST_OPND_HI;
        end
      end
      ST_OPND_HI: begin
        if (!taken)              fin = 1'b1;
        else if (op_q == OP_CALL) nxt = ST_INTERNAL;
        else                     nxt = ST_SETTLE;
      end
      ST_INTERNAL: begin
        if (op_q == OP_RET) begin
          if (taken) nxt = ST_POP_LO;
          else       fin = 1'b1;
        end else begin
          nxt = ST_PUSH_HI;
        end
      end
      ST_PUSH_HI: nxt = ST_PUSH_LO;
      ST_PUSH_LO: fin = 1'b1;
      ST_POP_LO:  nxt = ST_POP_HI;
      ST_POP_HI:  nxt = ST_SETTLE;
      ST_SETTLE:  fin = 1'b1;
      default:    fin = 1'b1;
    endcase
    if (fin) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_NONE;
      cc_q   <= 3'(CC_ALWAYS);
      fc_q   <= 1'b0;
      fz_q   <= 1'b0;
      done   <= 1'b0;
      ie_set <= 1'b0;
    end else begin
      state  <= nxt;
      done   <= fin;
      ie_set <= fin && (op_q == OP_RETI) && !idle;
      if (start_acc) begin
        op_q <= op_in;
        cc_q <= cond_sel;
        fc_q <= flag_c;
        fz_q <= flag_z;
      end
    end
  end

endmodule

// File: rtl/bsq_dpath.sv
`timescale 1ns/1ps
module bsq_dpath
  import bsq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int VEC_W      = 3,
  parameter int VEC_STRIDE = 8,
  localparam int ADDR_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_e             state,
  input  logic              start_acc,
  input  logic [2:0]        op_sel,
  input  logic [VEC_W-1:0]  vec_sel,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] hl_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] sp_q
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [DATA_W-1:0] lo_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [ADDR_W-1:0] rel_off;
  logic [ADDR_W-1:0] vec_addr;
  logic [ADDR_W-1:0] sp_dec;

  assign rel_off  = {{DATA_W{mem_rdata[DATA_W-1]}}, mem_rdata};
  assign vec_addr = ADDR_W'(vec_sel) * ADDR_W'(VEC_STRIDE);
  assign sp_dec   = sp_q - ONE;

  always_comb begin
    mem_addr  = pc_q;
    mem_wdata = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    case (state)
      ST_OPND_LO, ST_OPND_HI: begin
        mem_addr = pc_q;
        mem_rd   = 1'b1;
      end
      ST_POP_LO, ST_POP_HI: begin
        mem_addr = sp_q;
        mem_rd   = 1'b1;
      end
      ST_PUSH_HI: begin
        mem_addr  = sp_dec;
        mem_wdata = pc_q[ADDR_W-1:DATA_W];
        mem_wr    = 1'b1;
      end
      ST_PUSH_LO: begin
        mem_addr  = sp_dec;
        mem_wdata = pc_q[DATA_W-1:0];
        mem_wr    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sp_q  <= '0;
      lo_q  <= '0;
      tgt_q <= '0;
    end else if (start_acc) begin
      pc_q  <= (op_sel == 3'(OP_JHL)) ? hl_in : pc_in;
      sp_q  <= sp_in;
      tgt_q <= vec_addr;
    end else begin
      case (state)
        ST_OPND_LO: begin
          pc_q  <= pc_q + ONE;
          lo_q  <= mem_rdata;
          tgt_q <= pc_q + ONE + rel_off;
        end
        ST_OPND_HI: begin
          pc_q  <= pc_q + ONE;
          tgt_q <= {mem_rdata, lo_q};
        end
        ST_PUSH_HI: sp_q <= sp_dec;
        ST_PUSH_LO: begin
          sp_q <= sp_dec;
          pc_q <= tgt_q;
        end
        ST_POP_LO: begin
          sp_q <= sp_q + ONE;
          lo_q <= mem_rdata;
        end
        ST_POP_HI: begin
          sp_q  <= sp_q + ONE;
          tgt_q <= {mem_rdata, lo_q};
        end
        ST_SETTLE: pc_q <= tgt_q;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/branch_stack_seq.sv
`timescale 1ns/1ps
module branch_stack_seq
  import bsq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int VEC_W      = 3,
  parameter int VEC_STRIDE = 8,
  localparam int ADDR_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_sel,
  input  logic [2:0]        cond_sel,
  input  logic [VEC_W-1:0]  vec_sel,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] hl_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic              ie_set,
  output logic              done
);

  step_e      state_w;
  logic [2:0] cc_w;
  logic       fc_w;
  logic       fz_w;
  logic       taken_w;
  logic       start_acc_w;
  logic       idle_w;

  bsq_cond u_cond (
    .cc    (cc_w),
    .fc    (fc_w),
    .fz    (fz_w),
    .taken (taken_w)
  );

  bsq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_sel    (op_sel),
    .cond_sel  (cond_sel),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .taken     (taken_w),
    .state     (state_w),
    .cc_q      (cc_w),
    .fc_q      (fc_w),
    .fz_q      (fz_w),
    .start_acc (start_acc_w),
    .idle      (idle_w),
    .done      (done),
    .ie_set    (ie_set)
  );

  bsq_dpath #(
    .DATA_W     (DATA_W),
    .VEC_W      (VEC_W),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_w),
    .start_acc (start_acc_w),
    .op_sel    (op_sel),
    .vec_sel   (vec_sel),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .hl_in     (hl_in),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .pc_q      (pc_out),
    .sp_q      (sp_out)
  );

endmodule

// File: rtl/bsq_chk.sv
`timescale 1ns/1ps
module bsq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              idle,
  input logic [2:0]        op_sel,
  input logic [ADDR_W-1:0] hl_in,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              done,
  input logic              ie_set,
  input logic [ADDR_W-1:0] pc_out,
  input logic [ADDR_W-1:0] sp_out
);

  // R12
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R12
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (sp_out == $past(sp_out) - ADDR_W'(1)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(pc_out) && $stable(sp_out)));

  // R7
  ie_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ie_set |-> done);

  // R9
  jump_hl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && op_sel == 3'd6) |=> (done && pc_out == $past(hl_in)));

endmodule

bind branch_stack_seq bsq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .idle   (idle_w),
  .op_sel (op_sel),
  .hl_in  (hl_in),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .done   (done),
  .ie_set (ie_set),
  .pc_out (pc_out),
  .sp_out (sp_out)
);

// File: tb/branch_stack_seq_bench.sv
`timescale 1ns/1ps
module branch_stack_seq_bench;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  cc;
    logic        fc;
    logic        fz;
    logic [2:0]  vsel;
    logic [15:0] pc;
    logic [15:0] sp;
    logic [15:0] hl;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 16'h1234, 16'hD000, 16'h0000, 4'd4},
    '{3'd0, 3'd1, 1'b1, 1'b0, 3'd0, 16'h3456, 16'hD000, 16'h0000, 4'd4},
    '{3'd0, 3'd1, 1'b0, 1'b0, 3'd0, 16'h3456, 16'hD000, 16'h0000, 4'd3},
    '{3'd0, 3'd4, 1'b0, 1'b1, 3'd0, 16'h0100, 16'hD000, 16'h0000, 4'd3},
    '{3'd0, 3'd3, 1'b0, 1'b1, 3'd0, 16'h7001, 16'hD000, 16'h0000, 4'd4},
    '{3'd1, 3'd0, 1'b0, 1'b0, 3'd0, 16'h2005, 16'hD000, 16'h0000, 4'd3},
    '{3'd1, 3'd2, 1'b0, 1'b1, 3'd0, 16'h1080, 16'hD000, 16'h0000, 4'd3},
    '{3'd1, 3'd3, 1'b1, 1'b0, 3'd0, 16'h2005, 16'hD000, 16'h0000, 4'd2},
    '{3'd1, 3'd0, 1'b0, 1'b0, 3'd0, 16'hFFF0, 16'hD000, 16'h0000, 4'd3},
    '{3'd2, 3'd0, 1'b0, 1'b0, 3'd0, 16'h4000, 16'hD000, 16'h0000, 4'd6},
    '{3'd2, 3'd2, 1'b0, 1'b0, 3'd0, 16'h4000, 16'hD000, 16'h0000, 4'd3},
    '{3'd2, 3'd3, 1'b0, 1'b0, 3'd0, 16'h5555, 16'h0001, 16'h0000, 4'd6},
    '{3'd3, 3'd0, 1'b0, 1'b0, 3'd0, 16'h1000, 16'hC000, 16'h0000, 4'd4},
    '{3'd3, 3'd4, 1'b0, 1'b0, 3'd0, 16'h1000, 16'hC010, 16'h0000, 4'd5},
    '{3'd3, 3'd1, 1'b0, 1'b0, 3'd0, 16'h1000, 16'hC010, 16'h0000, 4'd2},
    '{3'd4, 3'd0, 1'b0, 1'b0, 3'd0, 16'h1000, 16'hFFFF, 16'h0000, 4'd4},
    '{3'd5, 3'd0, 1'b0, 1'b0, 3'd0, 16'h0150, 16'hD000, 16'h0000, 4'd4},
    '{3'd5, 3'd0, 1'b0, 1'b0, 3'd7, 16'h0150, 16'hD000, 16'h0000, 4'd4},
    '{3'd5, 3'd0, 1'b0, 1'b0, 3'd3, 16'hABCD, 16'hD000, 16'h0000, 4'd4},
    '{3'd6, 3'd0, 1'b0, 1'b0, 3'd0, 16'h0000, 16'hD000, 16'hBEEF, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [2:0]  cond_sel = '0;
  logic [2:0]  vec_sel = '0;
  logic        flag_c = 1'b0;
  logic        flag_z = 1'b0;
  logic [15:0] pc_in = '0;
  logic [15:0] sp_in = '0;
  logic [15:0] hl_in = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_rd;
  logic        mem_wr;
  logic [15:0] pc_out;
  logic [15:0] sp_out;
  logic        ie_set;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;
  int n_overlap = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  branch_stack_seq u_branch_stack_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_sel    (op_sel),
    .cond_sel  (cond_sel),
    .vec_sel   (vec_sel),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .hl_in     (hl_in),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .pc_out    (pc_out),
    .sp_out    (sp_out),
    .ie_set    (ie_set),
    .done      (done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R3/R2";
      3'd1: return "R4/R2";
      3'd2: return "R5/R2";
      3'd3: return "R6/R2";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Runs one operation starting at a negedge; flip toggles carry after acceptance.
  task automatic run_one(input vec_t v, input string tag, input bit flip);
    logic        tk;
    logic [15:0] epc, esp, ret, pcs, sps;
    logic [7:0]  o;
    logic        eie, gie;
    int          en, wn, lat;
    logic [15:0] ea [2];
    logic [7:0]  ed [2];
    logic [15:0] wa [2];
    logic [7:0]  wd [2];
    case (v.cc)
      3'd1: tk = v.fc;
      3'd2: tk = v.fz;
      3'd3: tk = !v.fc;
      3'd4: tk = !v.fz;
      default: tk = 1'b1;
    endcase
    epc = v.pc; esp = v.sp; eie = 1'b0; en = 0;
    ea[0] = '0; ea[1] = '0; ed[0] = '0; ed[1] = '0;
    case (v.op)
      3'd0: epc = tk ? {mem_f(v.pc + 16'd1), mem_f(v.pc)} : v.pc + 16'd2;
      3'd1: begin
        o = mem_f(v.pc);
        epc = tk ? v.pc + 16'd1 + {{8{o[7]}}, o} : v.pc + 16'd1;
      end
      3'd2: begin
        if (tk) begin
          ret = v.pc + 16'd2;
          epc = {mem_f(v.pc + 16'd1), mem_f(v.pc)};
          esp = v.sp - 16'd2;
          en = 2;
          ea[0] = v.sp - 16'd1; ed[0] = ret[15:8];
          ea[1] = v.sp - 16'd2; ed[1] = ret[7:0];
        end else begin
          epc = v.pc + 16'd2;
        end
      end
      3'd3, 3'd4: begin
        if (tk || v.op == 3'd4) begin
          epc = {mem_f(v.sp + 16'd1), mem_f(v.sp)};
          esp = v.sp + 16'd2;
        end
        eie = (v.op == 3'd4);
      end
      3'd5: begin
        epc = {10'd0, v.vsel, 3'd0};
        esp = v.sp - 16'd2;
        en = 2;
        ea[0] = v.sp - 16'd1; ed[0] = v.pc[15:8];
        ea[1] = v.sp - 16'd2; ed[1] = v.pc[7:0];
      end
      default: epc = v.hl;
    endcase
    op_sel = v.op; cond_sel = v.cc; vec_sel = v.vsel;
    flag_c = v.fc; flag_z = v.fz;
    pc_in = v.pc; sp_in = v.sp; hl_in = v.hl;
    start = 1'b1;
    wn = 0; lat = -1; gie = 1'b0; pcs = '0; sps = '0;
    wa[0] = '0; wa[1] = '0; wd[0] = '0; wd[1] = '0;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = 1'b0;
        if (flip) flag_c = ~flag_c;
      end
      if (mem_rd && mem_wr) n_overlap++;
      if (mem_wr) begin
        if (wn < 2) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
        wn++;
      end
      if (done) begin
        lat = k; gie = ie_set; pcs = pc_out; sps = sp_out;
        break;
      end
    end
    chk(lat == int'(v.lat), tag, "latency", 32'(lat), 32'(v.lat));
    chk(pcs == epc, tag, "pc", 32'(pcs), 32'(epc));
    chk(sps == esp, tag, "sp", 32'(sps), 32'(esp));
    chk(gie == eie, tag, "ie_set", 32'(gie), 32'(eie));
    chk(wn == en, tag, "write count", 32'(wn), 32'(en));
    if (en == 2 && wn == 2) begin
      for (int i = 0; i < 2; i++) begin
        chk(wa[i] == ea[i], tag, "write addr", 32'(wa[i]), 32'(ea[i]));
        chk(wd[i] == ed[i], tag, "write data", 32'(wd[i]), 32'(ed[i]));
      end
    end
    @(negedge clk);
    chk(!done, "R10", "done width", 32'(done), 32'd0);
  endtask

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    vec_t v;
    int dn;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pc_out == 16'd0 && sp_out == 16'd0, "R1", "pc/sp at reset",
        {pc_out, sp_out}, 32'd0);
    chk(!done && !ie_set && !mem_rd && !mem_wr, "R1", "strobes at reset",
        {28'd0, done, ie_set, mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_one(TBL[i], op_tag(TBL[i].op), 1'b0);
    end

    // R11 wrap of pushes through address zero and of relative offsets
    v = TBL[11];
    run_one(v, "R11", 1'b0);
    v = TBL[8];
    run_one(v, "R11", 1'b0);

    // R2 carry change after acceptance must not alter the taken jump
    v = TBL[1];
    run_one(v, "R2", 1'b1);

    // R10 start during a call is ignored
    op_sel = 3'd2; cond_sel = 3'd0; flag_c = 1'b0; flag_z = 1'b0;
    pc_in = 16'h4000; sp_in = 16'hD000; hl_in = 16'h1111;
    start = 1'b1;
    dn = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (k == 2) begin start = 1'b1; op_sel = 3'd6; end
      if (k == 3) start = 1'b0;
      if (done) dn++;
    end
    chk(dn == 1, "R10", "done count with busy start", 32'(dn), 32'd1);
    chk(pc_out == {mem_f(16'h4001), mem_f(16'h4000)}, "R10", "pc after busy start",
        32'(pc_out), 32'({mem_f(16'h4001), mem_f(16'h4000)}));
    chk(sp_out == 16'hCFFE, "R10", "sp after busy start", 32'(sp_out), 32'hCFFE);

    // R12 no simultaneous read and write anywhere above
    chk(n_overlap == 0, "R12", "rd/wr overlap cycles", 32'(n_overlap), 32'd0);

    // R1 reset in the middle of a call
    op_sel = 3'd2; cond_sel = 3'd0; pc_in = 16'h6000; sp_in = 16'hB000;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pc_out == 16'd0 && sp_out == 16'd0, "R1", "pc/sp after mid reset",
        {pc_out, sp_out}, 32'd0);
    chk(!mem_rd && !mem_wr && !done, "R1", "strobes after mid reset",
        {29'd0, mem_rd, mem_wr, done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule